// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller

This block collects 96 level-sensitive interrupt lines, split into three banks of 32, and presents two request outputs to a processor. One output is for the normal class and one for the fast class. Each line has its own mask bit, a software-raise bit, a 6-bit priority and a steering bit that places it in the fast class. A line is pending while its input is high or its software bit is set. An unmasked pending line is a candidate for the class it is steered to.

For each class, an arbiter waits in an armed state. When a candidate exists and the global mask is off, the arbiter picks the line with the smallest priority value and latches that line's number as the class code. It then raises the class request and disarms. The request and the code stay frozen until software re-arms the class through the control register. Software uses a 4 KB word-addressed register window to reach all state. Mask and software bits can be written whole, or changed atomically through separate set and clear words. A configuration write can soft-reset the whole controller.

Top module: `lvl_intc`

## Requirements
- R1: After reset, every mask bit is 1, every software bit, steer bit and priority is 0, both requests are low and both codes read 0. Offset 0x000 reads 0x21, offset 0x014 reads 1, and control 0x048 reads 0. A read returns its data on `bus_rdata_o` in the cycle after the one in which `bus_rd_i` was sampled.
- R2: Bank b has its registers at 0x080+0x20·b. Offset +0x04 writes the mask directly, +0x08 clears the mask bits written as 1, and +0x0C sets the mask bits written as 1. The two last words read 0, and the banks do not affect each other.
- R3: Offset +0x10 ORs the written bits into the software bits and reads them back. Offset +0x14 clears the written software bits. Offset +0x00 reads the raw input lines of the bank. Pending is input OR software bit.
- R4: Offset +0x18 reads pending AND NOT mask AND NOT steer. Offset +0x1C reads pending AND NOT mask AND steer.
- R5: The line configuration word for line n sits at 0x100+4·n. Bit 0 is the fast steer and bits 7:2 are the priority. Bit 1 and bits 31:8 read 0.
- R6: When a class is armed and has a candidate, its request rises on the next clock edge. At the same edge the class code (0x040 normal, 0x044 fast) latches the candidate with the smallest priority value. When priorities are equal, the higher line number wins.
- R7: A raised request and its code hold while new lines arrive, while masks change and while the code is read. Reading the code clears no pending bit.
- R8: Control bit 0 re-arms the normal class and bit 1 re-arms the fast class. The request falls at the write edge, and the class arbitrates again from the next edge. Control bit 2 is the global mask: it reads back at bit 2, and while it is set no request rises.
- R9: Writing 1 to bit 1 of 0x010 returns all state to the R1 values. Bit 0 of 0x010 is a read/write idle option. Offset 0x050 holds two read/write bits, and the higher written bits read back 0.
- R10: Offset 0x04C reads 0, and writes to it have no effect. Bank index 3 (0x0E0 to 0x0FF), line configuration words at or above line 96, and unmapped offsets read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 96 | Level interrupt inputs, line n on bit n |
| bus_wr_i | input | 1 | Write strobe for one word |
| bus_rd_i | input | 1 | Read strobe for one word |
| bus_addr_i | input | 12 | Byte address inside the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the strobe |
| norm_req_o | output | 1 | Normal-class request |
| fast_req_o | output | 1 | Fast-class request |

## Verification
The bench builds the controller with its default parameters: three banks of 32 lines and 6-bit priorities. With these values bank index 3 is the one index that falls inside the bank window without a bank behind it, so the bench can drive that out-of-range decode and check that it aliases nothing. Line numbers above 63 exercise the upper code bit, and line 70 in the third bank is steered to the fast class. Equal-priority ties are set up across the bank boundary (lines 5 and 40), so the rule that the higher line number wins is tested between two banks.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;
   localparam int unsigned BUS_W     = 32;
   localparam int unsigned ADDR_W    = 12;
   localparam logic [11:0] OFS_REV   = 12'h000;
   localparam logic [11:0] OFS_CFG   = 12'h010;
   localparam logic [11:0] OFS_STAT  = 12'h014;
   localparam logic [11:0] OFS_CODEN = 12'h040;
   localparam logic [11:0] OFS_CODEF = 12'h044;
   localparam logic [11:0] OFS_CTL   = 12'h048;
   localparam logic [11:0] OFS_PROT  = 12'h04C;
   localparam logic [11:0] OFS_IDLE  = 12'h050;
   localparam logic [11:0] OFS_LINE0 = 12'h100;

   typedef enum logic [2:0] {
      BK_RAW   = 3'd0,
      BK_MASK  = 3'd1,
      BK_MCLR  = 3'd2,
      BK_MSET  = 3'd3,
      BK_SSET  = 3'd4,
      BK_SCLR  = 3'd5,
      BK_PNORM = 3'd6,
      BK_PFAST = 3'd7
   } bank_reg_e;
endpackage

// File: rtl/lvl_intc_bank.sv
module lvl_intc_bank #(
   parameter int unsigned LPB    = 32,
   parameter int unsigned PRIO_W = 6,
   parameter int unsigned LPB_W  = $clog2(LPB)
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       srst_i,
   input  logic                       mask_wr_i,
   input  logic                       mclr_i,
   input  logic                       mset_i,
   input  logic                       sset_i,
   input  logic                       sclr_i,
   input  logic                       cfg_we_i,
   input  logic [LPB_W-1:0]           cfg_line_i,
   input  logic [31:0]                wdata_i,
   output logic [LPB-1:0]             mask_o,
   output logic [LPB-1:0]             sw_o,
   output logic [LPB-1:0]             steer_o,
   output logic [LPB-1:0][PRIO_W-1:0] prio_o
);
   logic [LPB-1:0]             mask_q, sw_q, steer_q;
   logic [LPB-1:0][PRIO_W-1:0] prio_q;
   logic [LPB-1:0]             wv;

   assign wv = wdata_i[LPB-1:0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mask_q  <= '1;
         sw_q    <= '0;
         steer_q <= '0;
         prio_q  <= '0;
      end else if (srst_i) begin
         mask_q  <= '1;
         sw_q    <= '0;
         steer_q <= '0;
         prio_q  <= '0;
      end else begin
         if (mask_wr_i)   mask_q <= wv;
         else if (mclr_i) mask_q <= mask_q & ~wv;
         else if (mset_i) mask_q <= mask_q | wv;
         if (sset_i)      sw_q   <= sw_q | wv;
         else if (sclr_i) sw_q   <= sw_q & ~wv;
         if (cfg_we_i) begin
            steer_q[cfg_line_i] <= wdata_i[0];
            prio_q[cfg_line_i]  <= wdata_i[2 +: PRIO_W];
         end
      end
   end

   assign mask_o  = mask_q;
   assign sw_o    = sw_q;
   assign steer_o = steer_q;
   assign prio_o  = prio_q;

   // R2: a mask-set word leaves every written bit masked
   a_r2_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mset_i && !srst_i && !mask_wr_i && !mclr_i) |=> ((mask_q & $past(wv)) == $past(wv)));

   // R3: a software-clear word removes every written bit
   a_r3_sw_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sclr_i && !sset_i && !srst_i) |=> ((sw_q & $past(wv)) == '0));
endmodule

// File: rtl/lvl_intc_arb.sv
module lvl_intc_arb #(
   parameter int unsigned NUM_LINES = 96,
   parameter int unsigned PRIO_W    = 6,
   parameter int unsigned CODE_W    = $clog2(NUM_LINES)
) (
   input  logic                             clk_i,
   input  logic                             rst_ni,
   input  logic                             srst_i,
   input  logic [NUM_LINES-1:0]             cand_i,
   input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_i,
   input  logic                             gmask_i,
   input  logic                             rearm_i,
   output logic                             req_o,
   output logic [CODE_W-1:0]                code_o
);
   logic              req_q;
   logic [CODE_W-1:0] code_q, best_i;
   logic [PRIO_W-1:0] best_p;
   logic              hit;

   // smallest value wins; the later line wins a tie
   always_comb begin
      best_p = '1;
      best_i = '0;
      hit    = |cand_i;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (cand_i[i] && (prio_i[i] <= best_p)) begin
            best_p = prio_i[i];
            best_i = CODE_W'(i);
         end
      end
   end

   // armed state is the complement of the request
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         req_q  <= 1'b0;
         code_q <= '0;
      end else if (srst_i) begin
         req_q  <= 1'b0;
         code_q <= '0;
      end else if (rearm_i) begin
         req_q  <= 1'b0;
      end else if (!req_q && hit && !gmask_i) begin
         req_q  <= 1'b1;
         code_q <= best_i;
      end
   end

   assign req_o  = req_q;
   assign code_o = code_q;

   // R6: a latched code names a real line
   a_r6_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_q |-> (code_q < CODE_W'(NUM_LINES)));

   // R6: the latched line was a candidate one cycle earlier
   a_r6_winner_was_cand: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(req_q) |-> ((($past(cand_i) >> code_q) & NUM_LINES'(1)) != '0));

   // R7: request and code hold until re-armed
   a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_q && !rearm_i && !srst_i) |=> (req_q && $stable(code_q)));

   // R8: global mask prevents a new request
   a_r8_gmask_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gmask_i && !req_q) |=> !req_q);

   // R9: soft reset drops the request
   a_r9_srst_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      srst_i |=> !req_q);
endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
   import lvl_intc_pkg::*;
#(
   parameter int unsigned NUM_BANKS      = 3,
   parameter int unsigned LINES_PER_BANK = 32,
   parameter int unsigned PRIO_W         = 6,
   parameter logic [7:0]  REV_ID         = 8'h21
) (
   input  logic                                clk_i,
   input  logic                                rst_ni,
   input  logic [NUM_BANKS*LINES_PER_BANK-1:0] line_i,
   input  logic                                bus_wr_i,
   input  logic                                bus_rd_i,
   input  logic [11:0]                         bus_addr_i,
   input  logic [31:0]                         bus_wdata_i,
   output logic [31:0]                         bus_rdata_o,
   output logic                                norm_req_o,
   output logic                                fast_req_o
);
   localparam int unsigned LPB       = LINES_PER_BANK;
   localparam int unsigned NUM_LINES = NUM_BANKS * LPB;
   localparam int unsigned LPB_W     = $clog2(LPB);
   localparam int unsigned CODE_W    = $clog2(NUM_LINES);

   if (LPB != 32) begin : g_bad_lpb
      $error("lvl_intc: LINES_PER_BANK must equal the 32-bit word width");
   end
   if (NUM_BANKS < 1 || NUM_BANKS > 4) begin : g_bad_banks
      $error("lvl_intc: NUM_BANKS must lie in 1..4");
   end
   if (PRIO_W < 1 || PRIO_W > 6) begin : g_bad_prio
      $error("lvl_intc: PRIO_W must lie in 1..6");
   end

   logic [11:0]     waddr;
   logic            bank_ok, line_ok;
   logic [1:0]      bank_sel;
   bank_reg_e       bank_reg;
   logic [9:0]      line_idx;
   logic [CODE_W-1:0] line_sel;
   int unsigned     bbase;

   assign waddr    = {bus_addr_i[11:2], 2'b00};
   assign bank_sel = waddr[6:5];
   assign bank_reg = bank_reg_e'(waddr[4:2]);
   assign bank_ok  = (waddr[11:7] == 5'b00001) && (32'(bank_sel) < NUM_BANKS);
   assign line_idx = waddr[11:2] - 10'd64;
   assign line_ok  = (waddr >= OFS_LINE0) && (32'(line_idx) < NUM_LINES);
   assign line_sel = line_idx[CODE_W-1:0];
   assign bbase    = 32'(bank_sel) * LPB;

   logic srst, cfg_wr, ctl_wr;
   logic [1:0] rearm;
   assign cfg_wr   = bus_wr_i && (waddr == OFS_CFG);
   assign ctl_wr   = bus_wr_i && (waddr == OFS_CTL);
   assign srst     = cfg_wr && bus_wdata_i[1];
   assign rearm[0] = ctl_wr && bus_wdata_i[0];
   assign rearm[1] = ctl_wr && bus_wdata_i[1];

   logic       autoidle_q, gmask_q;
   logic [1:0] idle_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         autoidle_q <= 1'b0;
         gmask_q    <= 1'b0;
         idle_q     <= '0;
      end else if (srst) begin
         autoidle_q <= 1'b0;
         gmask_q    <= 1'b0;
         idle_q     <= '0;
      end else begin
         if (cfg_wr) autoidle_q <= bus_wdata_i[0];
         if (ctl_wr) gmask_q    <= bus_wdata_i[2];
         if (bus_wr_i && waddr == OFS_IDLE) idle_q <= bus_wdata_i[1:0];
      end
   end

   logic [NUM_LINES-1:0]             mask_all, sw_all, steer_all, pend_all;
   logic [NUM_LINES-1:0][PRIO_W-1:0] prio_all;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic bk_hit, cfg_hit;
      assign bk_hit  = bus_wr_i && bank_ok && (bank_sel == 2'(b));
      assign cfg_hit = bus_wr_i && line_ok && (line_idx[9:LPB_W] == (10 - LPB_W)'(b));
      lvl_intc_bank #(.LPB(LPB), .PRIO_W(PRIO_W), .LPB_W(LPB_W)) u_bank (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .srst_i     (srst),
         .mask_wr_i  (bk_hit && bank_reg == BK_MASK),
         .mclr_i     (bk_hit && bank_reg == BK_MCLR),
         .mset_i     (bk_hit && bank_reg == BK_MSET),
         .sset_i     (bk_hit && bank_reg == BK_SSET),
         .sclr_i     (bk_hit && bank_reg == BK_SCLR),
         .cfg_we_i   (cfg_hit),
         .cfg_line_i (line_idx[LPB_W-1:0]),
         .wdata_i    (bus_wdata_i),
         .mask_o     (mask_all[b*LPB +: LPB]),
         .sw_o       (sw_all[b*LPB +: LPB]),
         .steer_o    (steer_all[b*LPB +: LPB]),
         .prio_o     (prio_all[b*LPB +: LPB])
      );
   end

   assign pend_all = line_i | sw_all;

   logic [1:0]        req_w;
   logic [CODE_W-1:0] code_w [2];

   for (genvar c = 0; c < 2; c++) begin : g_cls
      logic [NUM_LINES-1:0] cand;
      assign cand = pend_all & ~mask_all & ((c == 1) ? steer_all : ~steer_all);
      lvl_intc_arb #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .CODE_W(CODE_W)) u_arb (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .srst_i  (srst),
         .cand_i  (cand),
         .prio_i  (prio_all),
         .gmask_i (gmask_q),
         .rearm_i (rearm[c]),
         .req_o   (req_w[c]),
         .code_o  (code_w[c])
      );
   end

   assign norm_req_o = req_w[0];
   assign fast_req_o = req_w[1];

   logic [31:0] rd_val, rdata_q;
   always_comb begin
      rd_val = '0;
      if (bank_ok) begin
         unique case (bank_reg)
            BK_RAW:   rd_val = line_i[bbase +: LPB];
            BK_MASK:  rd_val = mask_all[bbase +: LPB];
            BK_SSET:  rd_val = sw_all[bbase +: LPB];
            BK_PNORM: rd_val = pend_all[bbase +: LPB] & ~mask_all[bbase +: LPB] & ~steer_all[bbase +: LPB];
            BK_PFAST: rd_val = pend_all[bbase +: LPB] & ~mask_all[bbase +: LPB] & steer_all[bbase +: LPB];
            default:  rd_val = '0;
         endcase
      end else if (line_ok) begin
         rd_val = (32'(prio_all[line_sel]) << 2) | 32'(steer_all[line_sel]);
      end else begin
         case (waddr)
            OFS_REV:   rd_val = 32'(REV_ID);
            OFS_CFG:   rd_val = 32'(autoidle_q);
            OFS_STAT:  rd_val = 32'd1;
            OFS_CODEN: rd_val = 32'(code_w[0]);
            OFS_CODEF: rd_val = 32'(code_w[1]);
            OFS_CTL:   rd_val = 32'(gmask_q) << 2;
            OFS_IDLE:  rd_val = 32'(idle_q);
            default:   rd_val = '0;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       rdata_q <= '0;
      else if (bus_rd_i) rdata_q <= rd_val;
   end
   assign bus_rdata_o = rdata_q;

   // R9: soft reset releases the global mask and idle option
   a_r9_srst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      srst |=> (!gmask_q && !autoidle_q && idle_q == 2'b00));

   // R1: a read returns the value decoded in the strobe cycle
   a_r1_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_rd_i |=> (bus_rdata_o == $past(rd_val)));
endmodule

// File: tb/lvl_intc_tb_top.sv
module lvl_intc_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [95:0] lines = '0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        nreq, freq;
   int          checks = 0, fails = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   lvl_intc dut_i (
      .clk_i(clk), .rst_ni(rst_n), .line_i(lines),
      .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata), .norm_req_o(nreq), .fast_req_o(freq)
   );

   typedef struct packed {
      logic        is_wr;
      logic [3:0]  req;
      logic [11:0] a;
      logic [31:0] d;
   } vec_t;

   // register walk: R1 reset values, R2 masks, R5 line words, R9 idle, R10 holes
   localparam vec_t TBL [30] = '{
      '{1'b0, 4'd1,  12'h000, 32'h0000_0021},
      '{1'b0, 4'd1,  12'h014, 32'h0000_0001},
      '{1'b0, 4'd1,  12'h084, 32'hFFFF_FFFF},
      '{1'b0, 4'd1,  12'h0C4, 32'hFFFF_FFFF},
      '{1'b1, 4'd2,  12'h088, 32'h0000_00F0},
      '{1'b0, 4'd2,  12'h084, 32'hFFFF_FF0F},
      '{1'b1, 4'd2,  12'h08C, 32'h0000_0030},
      '{1'b0, 4'd2,  12'h084, 32'hFFFF_FF3F},
      '{1'b1, 4'd2,  12'h0A4, 32'h1234_5678},
      '{1'b0, 4'd2,  12'h0A4, 32'h1234_5678},
      '{1'b0, 4'd2,  12'h084, 32'hFFFF_FF3F},
      '{1'b1, 4'd2,  12'h0A4, 32'hFFFF_FFFF},
      '{1'b1, 4'd5,  12'h110, 32'h0000_00FF},
      '{1'b0, 4'd5,  12'h110, 32'h0000_00FD},
      '{1'b1, 4'd5,  12'h110, 32'h0000_0000},
      '{1'b0, 4'd5,  12'h110, 32'h0000_0000},
      '{1'b1, 4'd10, 12'h04C, 32'h0000_0001},
      '{1'b0, 4'd10, 12'h04C, 32'h0000_0000},
      '{1'b1, 4'd9,  12'h050, 32'h0000_0007},
      '{1'b0, 4'd9,  12'h050, 32'h0000_0003},
      '{1'b1, 4'd9,  12'h050, 32'h0000_0000},
      '{1'b1, 4'd9,  12'h010, 32'h0000_0001},
      '{1'b0, 4'd9,  12'h010, 32'h0000_0001},
      '{1'b1, 4'd9,  12'h010, 32'h0000_0000},
      '{1'b1, 4'd10, 12'h0E8, 32'hFFFF_FFFF},
      '{1'b0, 4'd10, 12'h0E4, 32'h0000_0000},
      '{1'b0, 4'd10, 12'h084, 32'hFFFF_FF3F},
      '{1'b0, 4'd10, 12'h0C4, 32'hFFFF_FFFF},
      '{1'b0, 4'd10, 12'h3FC, 32'h0000_0000},
      '{1'b0, 4'd1,  12'h048, 32'h0000_0000}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      rd = 1'b1; addr = a;
      @(negedge clk);
      d = rdata; rd = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] v;
      bus_read(a, v);
      chk(tag, v, exp);
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 normal request after reset", 32'(nreq), 0);
      chk("R1 fast request after reset", 32'(freq), 0);
      rd_chk("R1 normal code after reset", 12'h040, 0);

      for (int i = 0; i < 30; i++) begin
         if (TBL[i].is_wr) bus_write(TBL[i].a, TBL[i].d);
         else begin
            bus_read(TBL[i].a, v);
            chk($sformatf("R%0d table row %0d", TBL[i].req, i), v, TBL[i].d);
         end
      end

      // R6: equal priority across banks, higher line wins
      bus_write(12'h088, 32'h0000_0020);
      bus_write(12'h0A8, 32'h0000_0100);
      @(negedge clk);
      lines[5] = 1'b1; lines[40] = 1'b1;
      settle(2);
      chk("R6 normal request rises", 32'(nreq), 1);
      rd_chk("R6 tie goes to line 40", 12'h040, 40);
      rd_chk("R7 code read again unchanged", 12'h040, 40);
      rd_chk("R7 pending kept after code read", 12'h098, 32'h0000_0020);
      rd_chk("R3 raw input view bank0", 12'h080, 32'h0000_0020);

      // R6: smaller priority value wins after re-arm (R8)
      bus_write(12'h114, 32'h0000_0008);
      bus_write(12'h1A0, 32'h0000_001C);
      rd_chk("R5 line 40 word readback", 12'h1A0, 32'h0000_001C);
      chk("R7 request held across config", 32'(nreq), 1);
      bus_write(12'h048, 32'h0000_0001);
      chk("R8 request drops at re-arm", 32'(nreq), 0);
      settle(2);
      chk("R8 request returns after re-arm", 32'(nreq), 1);
      rd_chk("R6 lowest value line 5 wins", 12'h040, 5);

      // fast class on line 70
      bus_write(12'h218, 32'h0000_0001);
      bus_write(12'h0C8, 32'h0000_0040);
      @(negedge clk);
      lines[70] = 1'b1;
      settle(2);
      chk("R6 fast request rises", 32'(freq), 1);
      rd_chk("R6 fast code is line 70", 12'h044, 70);
      rd_chk("R4 bank2 pending fast", 12'h0DC, 32'h0000_0040);
      rd_chk("R4 bank2 pending normal", 12'h0D8, 32'h0000_0000);
      rd_chk("R7 normal code kept", 12'h040, 5);

      // R8: global mask
      bus_write(12'h048, 32'h0000_0005);
      chk("R8 re-arm under global mask drops", 32'(nreq), 0);
      settle(3);
      chk("R8 global mask holds request low", 32'(nreq), 0);
      rd_chk("R8 global mask readback", 12'h048, 32'h0000_0004);
      bus_write(12'h048, 32'h0000_0000);
      settle(2);
      chk("R8 request after mask release", 32'(nreq), 1);
      rd_chk("R6 code after release", 12'h040, 5);

      // R3 software bits and R4 normal pending view
      bus_write(12'h090, 32'h0000_0200);
      rd_chk("R3 software bits readback", 12'h090, 32'h0000_0200);
      rd_chk("R4 masked software line hidden", 12'h098, 32'h0000_0020);
      bus_write(12'h088, 32'h0000_0200);
      rd_chk("R4 unmasked software line shown", 12'h098, 32'h0000_0220);
      bus_write(12'h094, 32'h0000_0200);
      rd_chk("R3 software clear", 12'h090, 32'h0000_0000);
      rd_chk("R3 pending after software clear", 12'h098, 32'h0000_0020);
      bus_write(12'h090, 32'h0000_0080);
      lines[5] = 1'b0;
      rd_chk("R3 software bit keeps line pending", 12'h098, 32'h0000_0080);

      // R9 soft reset
      bus_write(12'h010, 32'h0000_0002);
      chk("R9 normal request after soft reset", 32'(nreq), 0);
      settle(2);
      chk("R9 fast request stays low", 32'(freq), 0);
      rd_chk("R9 mask restored", 12'h084, 32'hFFFF_FFFF);
      rd_chk("R9 software bits cleared", 12'h090, 32'h0000_0000);
      rd_chk("R9 line word cleared", 12'h114, 32'h0000_0000);
      rd_chk("R9 fast code cleared", 12'h044, 32'h0000_0000);
      rd_chk("R9 raw inputs still visible", 12'h0A0, 32'h0000_0100);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule